// File: doc/BRIEF.md
# PQ Interrupt Source Controller

This block holds the two-bit delivery state of one interrupt source. P marks an event that has been notified and is still in flight. Q records that a further trigger arrived while P was set. A device raises the source with a one-cycle trigger pulse or with a held level input. The first trigger from the idle state emits a one-cycle notification toward the event router. Later triggers are latched in Q, so none is lost while the first event is outstanding.

Software drives the state only through side-effecting accesses on a small load/store port. The operation comes from bits [11:8] of the access offset. Each mapped load returns the state that held before the load. Four loads force the state to a chosen value, which is how software masks, unmasks, silences or retriggers the source. Two end-of-interrupt forms exist. The message form clears the state and fires again if Q was set. The level form clears the state and ignores Q, because a level that is still high fires again on its own. The message-form EOI is also available as a store. A fold mode corrects offsets issued by software that expects shifted operation codes.

Top module: `pq_source_ctrl`

## Requirements
- R1: After reset the state is PQ = 01 (masked), notify_o and rvalid_o are low, and the first set load returns 01.
- R2: The operation code is offset bits [11:8] after any folding. Code 0x0 is the level EOI, 0x4 is the message EOI, and 0xC to 0xF force PQ to the value in code bits [9:8] (P = bit 9, Q = bit 8). Offset bits [7:0] are ignored.
- R3: A load is answered one cycle later, with rvalid_o high for exactly that cycle. For a mapped load, rdata_o carries the previous P in bit 1 and Q in bit 0, and the upper bits are zero. A load to an unmapped code returns zero and leaves the state unchanged.
- R4: A trigger (trig_i or level_i high) in state 00 moves the state to 10 and pulses notify_o in the next cycle. In state 10 it moves the state to 11. In 01 or 11 the state is unchanged and there is no notification.
- R5: A set load forces the state. In 01 every trigger is dropped. In 10 no notification is sent, but a trigger is latched and gives 11.
- R6: A message EOI (a load or a store at code 0x4) clears the state to 00. If the old Q was 1, it then fires a trigger internally, which gives 10 and a notification.
- R7: A level EOI load (code 0x0) clears the state to 00 without looking at Q. The source is notified again only if level_i is high in the same cycle.
- R8: A store to any code other than 0x4 has no effect on the state, and no store ever raises rvalid_o.
- R9: With fold_off_i high, the offset is replaced by offset | (offset << 4), truncated to 12 bits, before decoding.
- R10: When an access and a trigger arrive in the same cycle, the access is applied first. The trigger then acts on the result, and an internal refire counts before the external trigger.
- R11: A set-11 load followed by a message EOI produces exactly one notification and leaves the state at 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | One-cycle trigger pulse from a message-type device |
| level_i | input | 1 | Level request; counts as a trigger in every cycle it is high |
| fold_off_i | input | 1 | Folds the offset with itself shifted left by 4 before decoding |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = store, 0 = load |
| off_i | input | 12 | Access offset; bits [11:8] select the operation |
| notify_o | output | 1 | One-cycle notification toward the event router |
| rvalid_o | output | 1 | Load response valid |
| rdata_o | output | 8 | Load response data: previous PQ in bits [1:0] |

## Verification
The directed sequences walk each state through every kind of trigger, so that dropping, latching and notifying can be told apart. They pair the message EOI with the level EOI at the same old Q and the same level, which separates refire-on-Q from refire-on-level. They issue an access and a trigger in the same cycle, which exposes the order in which the two are applied. The same offsets are sent with folding on and off, which shows whether the decode uses the folded offset. Random traffic over mapped, unmapped and low-bit-noisy offsets, with random triggers and level input, is compared cycle by cycle against a bench model of the requirements.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;
  typedef logic [1:0] pq_t;

  localparam int  P_BIT     = 1;
  localparam int  Q_BIT     = 0;
  localparam pq_t PQ_IDLE   = 2'b00;
  localparam pq_t PQ_OFF    = 2'b01;
  localparam pq_t PQ_PEND   = 2'b10;
  localparam pq_t PQ_QUEUED = 2'b11;

  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] CODE_LVL_EOI = 4'h0;
  localparam logic [OP_W-1:0] CODE_MSG_EOI = 4'h4;
  localparam logic [1:0]      CODE_SET_HI  = 2'b11;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_LVL_EOI,
    OP_MSG_EOI,
    OP_SET
  } op_kind_e;
endpackage

// File: rtl/pq_op_decode.sv
module pq_op_decode
  import pq_src_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int OP_LSB    = 8,
  parameter int SWZ_SHIFT = 4
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic             fold_i,
  output op_kind_e         kind_o,
  output pq_t              set_val_o
);
  localparam int OP_MSB  = OP_LSB + OP_W - 1;
  localparam int SRC_LSB = OP_LSB - SWZ_SHIFT;
  localparam int SRC_MSB = OP_MSB - SWZ_SHIFT;

  logic [OP_W-1:0] code;
  logic            unused_low;

  assign unused_low = ^off_i[SRC_LSB-1:0];

  // folded offset restricted to the bits that reach the decode
  assign code = off_i[OP_MSB:OP_LSB] |
                (fold_i ? off_i[SRC_MSB:SRC_LSB] : '0);
  assign set_val_o = code[1:0];

  always_comb begin
    if (code == CODE_LVL_EOI)                 kind_o = OP_LVL_EOI;
    else if (code == CODE_MSG_EOI)            kind_o = OP_MSG_EOI;
    else if (code[OP_W-1 -: 2] == CODE_SET_HI) kind_o = OP_SET;
    else                                      kind_o = OP_NONE;
  end
endmodule

// File: rtl/pq_op_apply.sv
module pq_op_apply
  import pq_src_pkg::*;
(
  input  pq_t      pq_i,
  input  logic     load_i,
  input  logic     store_i,
  input  op_kind_e kind_i,
  input  pq_t      set_val_i,
  output pq_t      pq_o,
  output logic     refire_o,
  output logic     hit_o
);
  always_comb begin
    pq_o     = pq_i;
    refire_o = 1'b0;
    hit_o    = 1'b0;
    if (load_i) begin
      case (kind_i)
        OP_LVL_EOI: begin
          pq_o  = PQ_IDLE;
          hit_o = 1'b1;
        end
        OP_MSG_EOI: begin
          pq_o     = PQ_IDLE;
          refire_o = pq_i[Q_BIT];
          hit_o    = 1'b1;
        end
        OP_SET: begin
          pq_o  = set_val_i;
          hit_o = 1'b1;
        end
        default: ;
      endcase
    end else if (store_i && kind_i == OP_MSG_EOI) begin
      pq_o     = PQ_IDLE;
      refire_o = pq_i[Q_BIT];
    end
  end
endmodule

// File: rtl/pq_trig_step.sv
module pq_trig_step
  import pq_src_pkg::*;
(
  input  pq_t  pq_i,
  input  logic fire_i,
  output pq_t  pq_o,
  output logic notify_o
);
  always_comb begin
    pq_o     = pq_i;
    notify_o = 1'b0;
    if (fire_i) begin
      if (pq_i == PQ_IDLE) begin
        pq_o     = PQ_PEND;
        notify_o = 1'b1;
      end else if (pq_i == PQ_PEND) begin
        pq_o = PQ_QUEUED;
      end
    end
  end
endmodule

// File: rtl/pq_source_ctrl.sv
module pq_source_ctrl
  import pq_src_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int OP_LSB    = 8,
  parameter int SWZ_SHIFT = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              level_i,
  input  logic              fold_off_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic              notify_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  // stage 0: internal refire from EOI, stage 1: device trigger
  localparam int N_STAGE = 2;

  pq_t         pq_q;
  pq_t         op_pq;
  pq_t         set_val;
  op_kind_e    kind;
  logic        refire;
  logic        hit;
  logic        load;
  logic        store;
  logic        notify_q;
  logic        rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  pq_t               stage_pq [0:N_STAGE];
  logic [N_STAGE-1:0] stage_fire;
  logic [N_STAGE-1:0] stage_ntf;

  assign load  = req_i & ~we_i;
  assign store = req_i &  we_i;

  pq_op_decode #(
    .OFF_W    (OFF_W),
    .OP_LSB   (OP_LSB),
    .SWZ_SHIFT(SWZ_SHIFT)
  ) u_dec (
    .off_i    (off_i),
    .fold_i   (fold_off_i),
    .kind_o   (kind),
    .set_val_o(set_val)
  );

  pq_op_apply u_apply (
    .pq_i     (pq_q),
    .load_i   (load),
    .store_i  (store),
    .kind_i   (kind),
    .set_val_i(set_val),
    .pq_o     (op_pq),
    .refire_o (refire),
    .hit_o    (hit)
  );

  assign stage_pq[0] = op_pq;
  assign stage_fire  = {trig_i | level_i, refire};

  for (genvar g = 0; g < N_STAGE; g++) begin : g_step
    pq_trig_step u_step (
      .pq_i    (stage_pq[g]),
      .fire_i  (stage_fire[g]),
      .pq_o    (stage_pq[g+1]),
      .notify_o(stage_ntf[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pq_q     <= PQ_OFF;
      notify_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      pq_q     <= stage_pq[N_STAGE];
      notify_q <= |stage_ntf;
      rvalid_q <= load;
      if (load) rdata_q <= hit ? DATA_W'(pq_q) : '0;
    end
  end

  assign notify_o = notify_q;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/pq_source_chk.sv
module pq_source_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig_i,
  input logic              level_i,
  input logic              req_i,
  input logic              we_i,
  input logic              notify_o,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [1:0]        pq_q
);
  AST_NOTIFY_SETS_P: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> pq_q[1]); // R4

  AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pq_q == 2'b01 && !req_i) |=> !notify_o); // R5

  AST_PEND_LATCHES_Q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pq_q == 2'b10 && !req_i && trig_i) |=> (pq_q == 2'b11 && !notify_o)); // R4

  AST_IDLE_STATE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !trig_i && !level_i) |=> $stable(pq_q)); // R4

  AST_LOAD_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R3

  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o); // R8

  AST_LOAD_OLD_PQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> (rdata_o == '0 ||
                          rdata_o == DATA_W'($past(pq_q)))); // R3
endmodule

bind pq_source_ctrl pq_source_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .trig_i  (trig_i),
  .level_i (level_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .notify_o(notify_o),
  .rvalid_o(rvalid_o),
  .rdata_o (rdata_o),
  .pq_q    (pq_q)
);

// File: tb/tb_pq_source_ctrl.sv
module tb_pq_source_ctrl;
  localparam int OFF_W  = 12;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic trig_i = 1'b0, level_i = 1'b0, fold_off_i = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [OFF_W-1:0] off_i = '0;
  logic notify_o, rvalid_o;
  logic [DATA_W-1:0] rdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [1:0] m_pq;

  always #4 clk = ~clk;

  pq_source_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig_i), .level_i(level_i),
    .fold_off_i(fold_off_i), .req_i(req_i), .we_i(we_i), .off_i(off_i),
    .notify_o(notify_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o)
  );

  // expected behaviour per requirement
  function automatic void model(input logic [1:0] pq, input logic req, we,
                                input logic [11:0] off, input logic fold,
                                input logic trg, lvl,
                                output logic [1:0] npq, output logic ntf,
                                output logic rv, output logic [7:0] rd);
    logic [11:0] eff;
    logic [3:0]  op;
    eff = fold ? (off | (off << 4)) : off;           // R9
    op  = eff[11:8];                                 // R2
    npq = pq; ntf = 1'b0; rv = req && !we; rd = 8'h00;
    if (req && !we) begin
      if (op == 4'h0) begin rd = {6'b0, pq}; npq = 2'b00; end      // R7
      else if (op == 4'h4) begin                                   // R6
        rd = {6'b0, pq}; npq = 2'b00;
        if (pq[0]) begin npq = 2'b10; ntf = 1'b1; end
      end else if (op[3:2] == 2'b11) begin rd = {6'b0, pq}; npq = op[1:0]; end // R5
    end else if (req && we && op == 4'h4) begin
      npq = 2'b00;
      if (pq[0]) begin npq = 2'b10; ntf = 1'b1; end
    end
    if (trg || lvl) begin                            // R10 order
      if (npq == 2'b00) begin npq = 2'b10; ntf = 1'b1; end
      else if (npq == 2'b10) npq = 2'b11;
    end
  endfunction

  task automatic step(input logic req, we, input logic [11:0] off,
                      input logic trg, lvl, input string tag);
    logic [1:0] e_pq; logic e_n, e_rv; logic [7:0] e_rd;
    @(negedge clk);
    req_i = req; we_i = we; off_i = off; trig_i = trg; level_i = lvl;
    model(m_pq, req, we, off, fold_off_i, trg, lvl, e_pq, e_n, e_rv, e_rd);
    @(posedge clk); #1;
    checks++;
    if (notify_o !== e_n || rvalid_o !== e_rv || (e_rv && rdata_o !== e_rd)) begin
      fails++;
      $display("FAIL %s: ntf/rv/rd act=%b/%b/%h exp=%b/%b/%h",
               tag, notify_o, rvalid_o, rdata_o, e_n, e_rv, e_rd);
    end
    m_pq = e_pq;
  endtask

  task automatic ld(input logic [11:0] off, input string tag);
    step(1'b1, 1'b0, off, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input logic trg, input string tag);
    step(1'b0, 1'b0, 12'h000, trg, 1'b0, tag);
  endtask

  // read state through a set load, then restore it
  task automatic peek(input string tag);
    logic [1:0] old;
    old = m_pq;
    ld(12'hF00, tag);
    ld(12'hC00 | {2'b00, old, 8'h00}, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    m_pq = 2'b01;
    #20 rst_ni = 1'b1;

    // R1 reset state
    idle(1'b0, "R1");
    idle(1'b1, "R1 masked trigger");
    ld(12'hF00, "R1 reset reads 01");
    ld(12'hC00, "R5 set 00 returns 11");

    // R4 trigger transitions
    idle(1'b1, "R4 00->10 notify");
    idle(1'b1, "R4 10->11");
    idle(1'b1, "R4 11 holds");
    peek("R4 readback");

    // R5 mask and silence
    ld(12'hD00, "R5 mask returns old P");
    idle(1'b1, "R5 masked drop");
    peek("R5 still masked");
    ld(12'hE00, "R5 set 10");
    idle(1'b1, "R5 10 latches Q");
    peek("R5 readback 11");

    // R6 message EOI
    ld(12'h400, "R6 EOI with Q refires");
    ld(12'h400, "R6 EOI without Q");
    peek("R6 cleared");

    // R11 retrigger sequence
    ld(12'hF00, "R11 set 11");
    step(1'b1, 1'b1, 12'h400, 1'b0, 1'b0, "R11 store EOI refires");
    peek("R11 ends at 10");

    // R8 stores off code 0x4 ignored
    step(1'b1, 1'b1, 12'hC00, 1'b0, 1'b0, "R8 store set ignored");
    step(1'b1, 1'b1, 12'h000, 1'b0, 1'b0, "R8 store lvl ignored");
    peek("R8 unchanged");

    // R3 unmapped load and R2 low bits ignored
    ld(12'h100, "R3 unmapped load zero");
    ld(12'h9A5, "R3 unmapped load zero");
    peek("R3 unchanged");
    ld(12'hD3F, "R2 low bits ignored");
    peek("R2 masked");

    // R7 level EOI versus message EOI
    ld(12'hF00, "R7 set 11");
    ld(12'h000, "R7 level EOI ignores Q");
    peek("R7 cleared");
    ld(12'hF00, "R7 set 11");
    step(1'b1, 1'b0, 12'h000, 1'b0, 1'b1, "R7 level still high renotifies");
    step(1'b0, 1'b0, 12'h000, 1'b0, 1'b1, "R7 level latches Q");
    idle(1'b0, "R7 level low");

    // R10 same-cycle ordering
    step(1'b1, 1'b0, 12'hE00, 1'b1, 1'b0, "R10 set10 then trigger");
    step(1'b1, 1'b0, 12'hC00, 1'b1, 1'b0, "R10 set00 then trigger");
    ld(12'hF00, "R10 set 11");
    step(1'b1, 1'b0, 12'h400, 1'b1, 1'b0, "R10 refire then trigger");
    peek("R10 readback 11");

    // R9 offset folding
    fold_off_i = 1'b1;
    ld(12'h0D0, "R9 folded set 01");
    ld(12'h0E0, "R9 folded set 10");
    ld(12'h040, "R9 folded message EOI");
    fold_off_i = 1'b0;
    ld(12'h0D0, "R9 unfolded is level EOI");
    peek("R9 readback");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] off;
      logic r, w, t, l;
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0: off = 12'h000;
        1, 2: off = 12'h400;
        3: off = 12'hC00;
        4: off = 12'hD00;
        5: off = 12'hE00;
        6: off = 12'hF00;
        default: off = 12'($urandom);
      endcase
      if ($urandom_range(0, 3) == 0) off[7:0] = 8'($urandom);
      r = ($urandom_range(0, 2) == 0);
      w = ($urandom_range(0, 3) == 0);
      t = ($urandom_range(0, 2) == 0);
      l = ($urandom_range(0, 15) == 0);
      fold_off_i = ($urandom_range(0, 7) == 0);
      step(r, w, off, t, l, "R2/R4/R6 random");
    end
    fold_off_i = 1'b0;
    idle(1'b0, "R4 final idle");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule